// File: doc/BRIEF.md
# Legacy Interrupt Cause Byte

This block collects interrupt events from a device's virtqueues and from its configuration logic into a single byte-wide cause register. It drives the level-sensitive legacy interrupt line and the Interrupt Status bit of the PCI status register. Any number of queue event pulses share one cause bit. A configuration-change pulse sets a second cause bit. The other six bits are reserved.

Host software reads the byte through a one-byte read port. The read returns the bits that are pending and clears all of them in the same access, and this drops the interrupt line. While message-signalled interrupts (MSI-X) are enabled, the legacy path is inert: events leave the byte untouched and neither output is driven. The read port has no back-pressure. A strobe is accepted in every cycle it is high. The data output always shows the live byte, and the clear takes effect at the clock edge that ends the strobe cycle.

Top module: `intx_cause_reg`

## Requirements
- R1: After reset the cause byte reads 0x00, and both the interrupt line and the interrupt status bit are low.
- R2: A pulse on any queue event input sets bit 0 of the byte. A pulse on the configuration event input sets bit 1. Each bit is visible in the cycle after the pulse.
- R3: Bits 7 to 2 of the byte always read as zero.
- R4: While MSI-X is disabled, the interrupt status output equals the OR of all bits of the byte.
- R5: The interrupt line follows the interrupt status output unless the interrupt-disable input is high. While that input is high, the line is low and the status output still reflects the byte.
- R6: A read strobe returns the current byte in the strobe cycle, and the byte reads 0x00 afterwards when no event coincides with the read.
- R7: An event that arrives in the same cycle as a read strobe is not lost. Its bit is set after the clear.
- R8: While MSI-X is enabled, events do not set any bit, and the interrupt line and the status output are both low, even if bits are already pending.
- R9: A set bit stays set until a read. Repeated events do not change the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| queue_evt | input | NUM_QUEUES | One-cycle event pulses, one per queue |
| cfg_evt | input | 1 | One-cycle configuration-change event pulse |
| msix_en | input | 1 | MSI-X enabled; the legacy path is inert while high |
| int_disable | input | 1 | Interrupt-disable bit from the PCI command register |
| rd_stb | input | 1 | Read-and-clear strobe of the cause byte |
| rd_data | output | 8 | Current cause byte |
| irq_line | output | 1 | Level-sensitive legacy interrupt line |
| int_status | output | 1 | PCI Interrupt Status bit |

## Verification
A cause bit stuck high would show as a non-zero value on the read that follows the first read. It would also keep the interrupt line asserted, so it is visible within two cycles of a clearing read. A missing set, or a clear that wipes a coinciding event, shows as a wrong byte on the very next read. A gating fault on the MSI-X or interrupt-disable path shows at once on the line or the status output, in the same cycle as the input change.

// File: rtl/intx_cause_pkg.sv
package intx_cause_pkg;
  localparam int unsigned CAUSE_W     = 8;
  localparam int unsigned QUEUE_BIT   = 0;
  localparam int unsigned CONFIG_BIT  = 1;
  localparam int unsigned NUM_CAUSES  = 2;

  typedef logic [CAUSE_W-1:0] cause_byte_t;
endpackage

// File: rtl/intx_sticky_bit.sv
module intx_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;

  // R7: a set wins over a coinciding clear
  assert_set_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q);
  // R6: a clear with no set empties the bit
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_q);
  // R9: a pending bit holds until cleared
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q && !clr_i) |=> q_q);
endmodule

// File: rtl/intx_line_gate.sv
module intx_line_gate
  import intx_cause_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cause_byte_t cause_i,
  input  logic        msix_en_i,
  input  logic        int_disable_i,
  output logic        irq_line_o,
  output logic        int_status_o
);
  logic any_cause;

  assign any_cause    = |cause_i;
  assign int_status_o = any_cause & ~msix_en_i;
  assign irq_line_o   = int_status_o & ~int_disable_i;

  assert_mask_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_disable_i |-> !irq_line_o);
  assert_msix_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msix_en_i |-> (!irq_line_o && !int_status_o));
  assert_line_implies_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line_o |-> int_status_o);
endmodule

// File: rtl/intx_cause_reg.sv
module intx_cause_reg
  import intx_cause_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_QUEUES-1:0] queue_evt,
  input  logic                  cfg_evt,
  input  logic                  msix_en,
  input  logic                  int_disable,
  input  logic                  rd_stb,
  output logic [CAUSE_W-1:0]    rd_data,
  output logic                  irq_line,
  output logic                  int_status
);
  logic [NUM_CAUSES-1:0] raw_evt;
  logic [NUM_CAUSES-1:0] set_vec;
  cause_byte_t           cause_q;

  always_comb begin
    raw_evt             = '0;
    raw_evt[QUEUE_BIT]  = |queue_evt;
    raw_evt[CONFIG_BIT] = cfg_evt;
  end

  assign set_vec = raw_evt & {NUM_CAUSES{~msix_en}};

  for (genvar b = 0; b < CAUSE_W; b++) begin : g_cause
    if (b < NUM_CAUSES) begin : g_live
      intx_sticky_bit u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[b]),
        .clr_i (rd_stb),
        .q_o   (cause_q[b])
      );
    end else begin : g_rsvd
      assign cause_q[b] = 1'b0;
    end
  end

  assign rd_data = cause_q;

  intx_line_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cause_i       (cause_q),
    .msix_en_i     (msix_en),
    .int_disable_i (int_disable),
    .irq_line_o    (irq_line),
    .int_status_o  (int_status)
  );

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CAUSE_W-1:NUM_CAUSES] == '0);
  assert_msix_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_en && !rd_stb) |=> $stable(rd_data));
  assert_status_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !msix_en |-> (int_status == (rd_data != '0)));
endmodule

// File: tb/intx_cause_reg_test.sv
module intx_cause_reg_test;
  localparam int NQ = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NQ-1:0] queue_evt = '0;
  logic          cfg_evt = 1'b0;
  logic          msix_en = 1'b0;
  logic          int_disable = 1'b0;
  logic          rd_stb = 1'b0;
  logic [7:0]    rd_data;
  logic          irq_line;
  logic          int_status;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  intx_cause_reg #(.NUM_QUEUES(NQ)) uut (
    .clk, .rst_n, .queue_evt, .cfg_evt, .msix_en, .int_disable,
    .rd_stb, .rd_data, .irq_line, .int_status
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data with the scoreboard at the falling edge
  always @(negedge clk) begin
    if (rd_stb) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected read", 8'h01, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
        check("R3 reserved bits", {2'b00, rd_data[7:2]}, 8'h00);
      end
    end
  end

  task automatic pulse(input logic [NQ-1:0] q, input logic c);
    @(posedge clk); #1;
    queue_evt = q; cfg_evt = c;
    @(posedge clk); #1;
    queue_evt = '0; cfg_evt = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] exp, input string tag,
                           input logic [NQ-1:0] q, input logic c);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_stb = 1'b1; queue_evt = q; cfg_evt = c;
    @(posedge clk); #1;
    rd_stb = 1'b0; queue_evt = '0; cfg_evt = 1'b0;
  endtask

  task automatic check_pins(input string tag, input logic irq, input logic sts);
    @(negedge clk);
    check({tag, " irq_line"}, {7'd0, irq_line}, {7'd0, irq});
    check({tag, " int_status"}, {7'd0, int_status}, {7'd0, sts});
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 byte", rd_data, 8'h00);
    check_pins("R1", 1'b0, 1'b0);
    rst_n = 1'b1;

    pulse(4'b0100, 1'b0);
    check_pins("R2 R4 R5 queue", 1'b1, 1'b1);
    read_byte(8'h01, "R2 queue bit", '0, 1'b0);
    read_byte(8'h00, "R6 cleared", '0, 1'b0);
    check_pins("R6 line drop", 1'b0, 1'b0);

    pulse('0, 1'b1);
    check_pins("R4 config", 1'b1, 1'b1);
    read_byte(8'h02, "R2 config bit", '0, 1'b0);

    pulse(4'b1001, 1'b1);
    pulse(4'b0010, 1'b0);
    pulse('0, 1'b1);
    read_byte(8'h03, "R9 sticky", '0, 1'b0);
    read_byte(8'h00, "R9 cleared", '0, 1'b0);

    int_disable = 1'b1;
    pulse(4'b0001, 1'b0);
    check_pins("R5 masked", 1'b0, 1'b1);
    int_disable = 1'b0;
    check_pins("R5 unmasked", 1'b1, 1'b1);

    read_byte(8'h01, "R7 read old", '0, 1'b1);
    read_byte(8'h02, "R7 survivor", '0, 1'b0);
    read_byte(8'h00, "R7 empty", '0, 1'b0);

    msix_en = 1'b1;
    pulse(4'b1111, 1'b1);
    check_pins("R8 inert", 1'b0, 1'b0);
    msix_en = 1'b0;
    read_byte(8'h00, "R8 no set", '0, 1'b0);

    pulse(4'b0010, 1'b0);
    msix_en = 1'b1;
    check_pins("R8 pending gated", 1'b0, 1'b0);
    msix_en = 1'b0;
    check_pins("R8 pending back", 1'b1, 1'b1);
    read_byte(8'h01, "R8 pending kept", '0, 1'b0);

    repeat (2) @(posedge clk);
    check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule